// File: doc/BRIEF.md
# Hardware Voice Activity Detector

This block watches one microphone channel out of a bundle of 1-bit pulse-density streams and raises a flag when the channel seems to carry speech. A processor can then sleep until the flag is raised. A decimator that belongs to the detector alone turns the selected bit stream into magnitude samples. The oversampling ratio is a power of two set by its own field. The samples are grouped into fixed-length frames. The energy of each frame is the sum of its sample magnitudes.

A noise-floor estimate tracks the quiet level of the channel. When the detector is enabled, it runs a warm-up of a programmable number of frames. During the warm-up the floor is seeded and refined, the decision output is held low, and a busy flag stays high. After the warm-up, each frame is compared with twice the floor plus a programmable margin. Only frames judged quiet refine the floor. A frame judged as speech sets a sticky flag. Software clears that flag by writing 1. An enable bit gates whether the flag drives the interrupt line. The current floor can always be read as a plain value.

Top module: `voice_activity_detector`

## Requirements
- R1: After synchronous reset, irq, voice_flag, voice_now, init_busy and noise_level are all 0.
- R2: A decimated sample closes after 2^osr_log2 ticks of pdm_tick. Its magnitude is |k - 2^osr_log2/2|, where k is the number of 1 bits that chan_sel's channel showed on those ticks, and the half value is 0 when osr_log2 is 0.
- R3: Frame energy is the sum of the magnitudes of 2^FRAME_LOG2 consecutive samples.
- R4: Once enable is high, init_busy stays high until the end of frame number init_frames+1, counted from when enable went high. voice_now stays 0 throughout that period.
- R5: The first frame after enable loads the noise floor with its energy. Later warm-up frames, and frames judged as not voice, update it to floor + ((E - floor) >>> 4), an arithmetic shift. Voice frames leave it unchanged. noise_level always shows the floor.
- R6: After the warm-up, a frame is voice only when E > 2*floor + threshold, a strict comparison. voice_now holds the verdict of the latest frame.
- R7: voice_flag is set by any voice frame. It stays set until a cycle in which flag_clr is 1. When both happen in the same cycle, the set wins.
- R8: irq equals voice_flag AND irq_en.
- R9: Channels other than the one chan_sel selects have no effect on energy, floor or verdict.
- R10: With enable low, the decimator count, the partial frame, the floor and voice_now are cleared, and init_busy reads 0. voice_flag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the detector; low clears it and restarts the warm-up |
| pdm_in | input | CHANNELS | One pulse-density bit per channel |
| pdm_tick | input | 1 | Marks a cycle where pdm_in carries a new bit |
| chan_sel | input | $clog2(CHANNELS) | Channel watched by the detector |
| osr_log2 | input | $clog2(OSR_LOG2_MAX+1) | log2 of the decimation ratio |
| init_frames | input | INIT_W | Warm-up length minus one, in frames |
| threshold | input | THR_W | Margin added to twice the floor |
| irq_en | input | 1 | Lets voice_flag drive irq |
| flag_clr | input | 1 | Write-1 clear of voice_flag |
| irq | output | 1 | Interrupt request |
| voice_flag | output | 1 | Sticky voice-detected flag |
| voice_now | output | 1 | Verdict of the latest frame |
| init_busy | output | 1 | Warm-up in progress |
| noise_level | output | OSR_LOG2_MAX+FRAME_LOG2 | Current noise-floor estimate |

## Verification
The case hardest to reach from the ports is a frame whose energy lands exactly on 2*floor + threshold, right after a floor update that used a negative difference. The arithmetic shift has to round toward minus infinity there. The bench gets there with a short frame length and a fixed density pattern of ones for each frame. A table of densities walks the floor through seeded, rising, exactly-equal and falling values. Separate runs cover the one-bit ratio, a partial frame dropped when enable goes low, and a single-frame warm-up.

// File: rtl/vad_pkg.sv
package vad_pkg;

    // Detector phase after enable
    typedef enum logic [1:0] {
        PH_SEED = 2'd0,
        PH_WARM = 2'd1,
        PH_RUN  = 2'd2
    } vad_phase_e;

    // Shift of the first-order noise smoother
    localparam int NOISE_SHIFT = 4;

    // One smoother step: floor moves 1/16 of the way toward energy,
    // with the shift rounding toward minus infinity.
    function automatic logic signed [31:0] smooth_step(
        input logic signed [31:0] floor_v,
        input logic signed [31:0] energy_v
    );
        logic signed [31:0] diff;
        diff = energy_v - floor_v;
        return floor_v + (diff >>> NOISE_SHIFT);
    endfunction

endpackage

// File: rtl/vad_decim.sv
module vad_decim #(
    parameter int CHANNELS     = 8,
    parameter int OSR_LOG2_MAX = 7
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                enable,
    input  logic [CHANNELS-1:0]                 pdm_in,
    input  logic                                pdm_tick,
    input  logic [$clog2(CHANNELS)-1:0]         chan_sel,
    input  logic [$clog2(OSR_LOG2_MAX+1)-1:0]   osr_log2,
    output logic                                samp_valid,
    output logic [OSR_LOG2_MAX-1:0]             samp_mag
);
    localparam int OSR_W = $clog2(OSR_LOG2_MAX + 1);
    localparam int CNT_W = OSR_LOG2_MAX + 1;
    localparam int MAG_W = OSR_LOG2_MAX;

    logic [OSR_W-1:0] osr_eff;
    logic [CNT_W-1:0] ratio, half, bit_cnt, ones_cnt, ones_next, dev;
    logic             sel_bit, last_bit;

    always_comb begin
        osr_eff   = (int'(osr_log2) > OSR_LOG2_MAX) ? OSR_W'(OSR_LOG2_MAX) : osr_log2;
        ratio     = CNT_W'(1) << osr_eff;
        half      = ratio >> 1;
        sel_bit   = pdm_in[chan_sel];
        last_bit  = (bit_cnt == ratio - CNT_W'(1));
        ones_next = ones_cnt + CNT_W'(sel_bit);
        dev       = (ones_next >= half) ? (ones_next - half) : (half - ones_next);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            bit_cnt    <= '0;
            ones_cnt   <= '0;
            samp_valid <= 1'b0;
            samp_mag   <= '0;
        end else begin
            samp_valid <= 1'b0;
            if (pdm_tick) begin
                if (last_bit) begin
                    bit_cnt    <= '0;
                    ones_cnt   <= '0;
                    samp_valid <= 1'b1;
                    samp_mag   <= MAG_W'(dev);
                end else begin
                    bit_cnt  <= bit_cnt + CNT_W'(1);
                    ones_cnt <= ones_next;
                end
            end
        end
    end

    // R2: a magnitude never exceeds half the ratio (or 1 at ratio 1)
    a_r2_mag_bound: assert property (@(posedge clk) disable iff (rst)
        samp_valid |-> (CNT_W'(samp_mag) <= ((half == '0) ? CNT_W'(1) : half)));

endmodule

// File: rtl/vad_energy.sv
module vad_energy #(
    parameter int MAG_W      = 7,
    parameter int FRAME_LOG2 = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enable,
    input  logic                        samp_valid,
    input  logic [MAG_W-1:0]            samp_mag,
    output logic                        frame_valid,
    output logic [MAG_W+FRAME_LOG2-1:0] frame_energy
);
    localparam int EN_W = MAG_W + FRAME_LOG2;

    logic [FRAME_LOG2-1:0] samp_cnt;
    logic [EN_W-1:0]       acc, sum_next;

    assign sum_next = acc + EN_W'(samp_mag);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            samp_cnt     <= '0;
            acc          <= '0;
            frame_valid  <= 1'b0;
            frame_energy <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (samp_valid) begin
                samp_cnt <= samp_cnt + FRAME_LOG2'(1);
                if (&samp_cnt) begin
                    acc          <= '0;
                    frame_valid  <= 1'b1;
                    frame_energy <= sum_next;
                end else begin
                    acc <= sum_next;
                end
            end
        end
    end

    // R3: a frame needs many samples, so frame strobes never touch
    a_r3_frame_spacing: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

endmodule

// File: rtl/vad_detector.sv
module vad_detector
    import vad_pkg::*;
#(
    parameter int EN_W   = 15,
    parameter int INIT_W = 4,
    parameter int THR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              frame_valid,
    input  logic [EN_W-1:0]   frame_energy,
    input  logic [INIT_W-1:0] init_frames,
    input  logic [THR_W-1:0]  threshold,
    input  logic              flag_clr,
    output logic              init_busy,
    output logic              voice_now,
    output logic              voice_flag,
    output logic [EN_W-1:0]   noise_floor
);
    localparam int CMP_W = ((EN_W + 1 > THR_W) ? EN_W + 1 : THR_W) + 1;

    vad_phase_e        phase;
    logic [INIT_W-1:0] warm_cnt;
    logic [EN_W-1:0]   floor_next;
    logic [CMP_W-1:0]  limit;
    logic              is_voice, set_flag;

    always_comb begin
        floor_next = EN_W'(smooth_step(32'(noise_floor), 32'(frame_energy)));
        limit      = (CMP_W'(noise_floor) << 1) + CMP_W'(threshold);
        is_voice   = (CMP_W'(frame_energy) > limit);
        set_flag   = enable && frame_valid && (phase == PH_RUN) && is_voice;
        init_busy  = enable && (phase != PH_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase       <= PH_SEED;
            warm_cnt    <= '0;
            voice_now   <= 1'b0;
            noise_floor <= '0;
        end else if (frame_valid) begin
            unique case (phase)
                PH_SEED: begin
                    noise_floor <= frame_energy;
                    warm_cnt    <= INIT_W'(1);
                    phase       <= (init_frames == '0) ? PH_RUN : PH_WARM;
                end
                PH_WARM: begin
                    noise_floor <= floor_next;
                    warm_cnt    <= warm_cnt + INIT_W'(1);
                    if (warm_cnt == init_frames) phase <= PH_RUN;
                end
                default: begin
                    voice_now <= is_voice;
                    if (!is_voice) noise_floor <= floor_next;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           voice_flag <= 1'b0;
        else if (set_flag) voice_flag <= 1'b1;
        else if (flag_clr) voice_flag <= 1'b0;
    end

    // R4: no verdict while the warm-up runs
    a_r4_quiet_during_init: assert property (@(posedge clk) disable iff (rst)
        init_busy |-> !voice_now);
    // R5: the floor moves only on a frame edge while enabled
    a_r5_floor_on_frame_only: assert property (@(posedge clk) disable iff (rst)
        (enable && !frame_valid) |=> $stable(noise_floor));
    // R6: a fresh voice verdict always comes with the flag
    a_r6_voice_sets_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(voice_now) |-> voice_flag);
    // R7: the flag only drops on a clear request
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (voice_flag && !flag_clr) |=> voice_flag);

endmodule

// File: rtl/voice_activity_detector.sv
module voice_activity_detector
    import vad_pkg::*;
#(
    parameter int CHANNELS     = 8,
    parameter int OSR_LOG2_MAX = 7,
    parameter int FRAME_LOG2   = 8,
    parameter int INIT_W       = 4,
    parameter int THR_W        = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    enable,
    input  logic [CHANNELS-1:0]                     pdm_in,
    input  logic                                    pdm_tick,
    input  logic [$clog2(CHANNELS)-1:0]             chan_sel,
    input  logic [$clog2(OSR_LOG2_MAX+1)-1:0]       osr_log2,
    input  logic [INIT_W-1:0]                       init_frames,
    input  logic [THR_W-1:0]                        threshold,
    input  logic                                    irq_en,
    input  logic                                    flag_clr,
    output logic                                    irq,
    output logic                                    voice_flag,
    output logic                                    voice_now,
    output logic                                    init_busy,
    output logic [OSR_LOG2_MAX+FRAME_LOG2-1:0]      noise_level
);
    localparam int MAG_W = OSR_LOG2_MAX;
    localparam int EN_W  = MAG_W + FRAME_LOG2;

    logic             samp_valid, frame_valid;
    logic [MAG_W-1:0] samp_mag;
    logic [EN_W-1:0]  frame_energy;

    vad_decim #(.CHANNELS(CHANNELS), .OSR_LOG2_MAX(OSR_LOG2_MAX)) u_decim (
        .clk(clk), .rst(rst), .enable(enable), .pdm_in(pdm_in), .pdm_tick(pdm_tick),
        .chan_sel(chan_sel), .osr_log2(osr_log2),
        .samp_valid(samp_valid), .samp_mag(samp_mag)
    );

    vad_energy #(.MAG_W(MAG_W), .FRAME_LOG2(FRAME_LOG2)) u_energy (
        .clk(clk), .rst(rst), .enable(enable), .samp_valid(samp_valid), .samp_mag(samp_mag),
        .frame_valid(frame_valid), .frame_energy(frame_energy)
    );

    vad_detector #(.EN_W(EN_W), .INIT_W(INIT_W), .THR_W(THR_W)) u_detector (
        .clk(clk), .rst(rst), .enable(enable), .frame_valid(frame_valid),
        .frame_energy(frame_energy), .init_frames(init_frames), .threshold(threshold),
        .flag_clr(flag_clr), .init_busy(init_busy), .voice_now(voice_now),
        .voice_flag(voice_flag), .noise_floor(noise_level)
    );

    assign irq = voice_flag & irq_en;

endmodule

// File: tb/voice_activity_detector_bench.sv
`timescale 1ns/1ps
module voice_activity_detector_bench;
    localparam int CH = 4;
    localparam int OSRM = 7;
    localparam int FL2 = 3;
    localparam int NSAMP = 1 << FL2;
    localparam int ROWS = 9;
    // densities of ones per sample (ratio 64), expected verdict, floor, busy
    localparam int TAB_K[ROWS]     = '{36, 40, 36, 41, 44, 42, 20, 32, 31};
    localparam int TAB_VOICE[ROWS] = '{0, 0, 0, 0, 1, 0, 1, 0, 0};
    localparam int TAB_FLOOR[ROWS] = '{32, 34, 33, 35, 35, 37, 37, 34, 32};
    localparam int TAB_BUSY[ROWS]  = '{1, 1, 0, 0, 0, 0, 0, 0, 0};

    logic clk = 0, rst = 1, enable = 0, pdm_tick = 0, irq_en = 1, flag_clr = 0;
    logic [CH-1:0] pdm_in = '0;
    logic [1:0] chan_sel = 2'd2;
    logic [2:0] osr_log2 = 3'd6;
    logic [3:0] init_frames = 4'd2;
    logic [15:0] threshold = 16'd10;
    logic irq, voice_flag, voice_now, init_busy;
    logic [OSRM+FL2-1:0] noise_level;
    int n_tests = 0, n_fail = 0, flag_exp = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    voice_activity_detector #(.CHANNELS(CH), .OSR_LOG2_MAX(OSRM), .FRAME_LOG2(FL2)) u_voice_activity_detector (
        .clk(clk), .rst(rst), .enable(enable), .pdm_in(pdm_in), .pdm_tick(pdm_tick),
        .chan_sel(chan_sel), .osr_log2(osr_log2), .init_frames(init_frames),
        .threshold(threshold), .irq_en(irq_en), .flag_clr(flag_clr), .irq(irq),
        .voice_flag(voice_flag), .voice_now(voice_now), .init_busy(init_busy),
        .noise_level(noise_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // samples on the selected channel carry k ones out of 2^osr; other channels stay at 1
    task automatic send_samples(input int k, input int count);
        for (int s = 0; s < count; s++) begin
            for (int b = 0; b < (1 << osr_log2); b++) begin
                pdm_in = '1;
                pdm_in[chan_sel] = (b < k);
                pdm_tick = 1;
                cyc(1);
                pdm_tick = 0;
                cyc(1);
            end
        end
        cyc(5);
    endtask

    initial begin
        cyc(3);
        @(negedge clk);
        chk("R1 irq", irq, 0);
        chk("R1 flag", voice_flag, 0);
        chk("R1 voice_now", voice_now, 0);
        chk("R1 init_busy", init_busy, 0);
        chk("R1 noise", noise_level, 0);
        rst = 0;
        enable = 1;
        cyc(1);
        @(negedge clk);
        chk("R4 busy after enable", init_busy, 1);

        // table walk: R2 R3 R5 R6 R7 R8 R9
        for (int i = 0; i < ROWS; i++) begin
            send_samples(TAB_K[i], NSAMP);
            if (TAB_VOICE[i] == 1) flag_exp = 1;
            @(negedge clk);
            chk($sformatf("R5/R9 floor row %0d", i), noise_level, TAB_FLOOR[i]);
            chk($sformatf("R6 verdict row %0d", i), voice_now, TAB_VOICE[i]);
            chk($sformatf("R4 busy row %0d", i), init_busy, TAB_BUSY[i]);
            chk($sformatf("R7 flag row %0d", i), voice_flag, flag_exp);
            chk($sformatf("R8 irq row %0d", i), irq, flag_exp);
        end

        // R7 write-1 clear
        cyc(1); flag_clr = 1; cyc(1); flag_clr = 0;
        @(negedge clk);
        chk("R7 cleared", voice_flag, 0);
        chk("R8 irq after clear", irq, 0);

        // R8 gated interrupt, R5 floor frozen on voice (floor 32, limit 74, E 96)
        irq_en = 0;
        send_samples(44, NSAMP);
        @(negedge clk);
        chk("R6 voice again", voice_now, 1);
        chk("R7 flag set", voice_flag, 1);
        chk("R8 irq masked", irq, 0);
        chk("R5 floor held on voice", noise_level, 32);
        irq_en = 1;
        #1;
        chk("R8 irq unmasked", irq, 1);

        // R10 disable clears state but keeps the flag
        cyc(1); enable = 0; cyc(2);
        @(negedge clk);
        chk("R10 busy low", init_busy, 0);
        chk("R10 floor cleared", noise_level, 0);
        chk("R10 verdict cleared", voice_now, 0);
        chk("R10 flag kept", voice_flag, 1);
        flag_clr = 1; cyc(1); flag_clr = 0;

        // ratio 1, single-frame warm-up, zero margin
        osr_log2 = 3'd0; init_frames = 4'd0; threshold = 16'd0;
        enable = 1;
        cyc(1);
        chk("R4 busy restart", init_busy, 1);
        send_samples(1, 4);           // partial frame, then dropped
        enable = 0; cyc(2); enable = 1; cyc(1);
        send_samples(0, NSAMP);       // E 0 seeds floor 0
        @(negedge clk);
        chk("R10 partial frame dropped", noise_level, 0);
        chk("R4 one-frame warm-up ends", init_busy, 0);
        chk("R4 no verdict at seed", voice_now, 0);
        send_samples(1, NSAMP);       // ratio 1: each 1 bit has magnitude 1, E 8 > 0
        @(negedge clk);
        chk("R2 ratio-1 voice", voice_now, 1);
        chk("R7 flag from ratio-1 frame", voice_flag, 1);
        chk("R5 floor held", noise_level, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule